// File: doc/BRIEF.md
# Pipelined Binary-Trie Longest-Prefix Lookup

This block finds the next hop for a destination address by walking a binary trie, one trie level per pipeline stage. Each stage has its own node RAM. A node holds a (child pointer, next-hop) pair for each branch. Stage k reads one node and tests address bit k, counted from the most significant end. It then picks the left pair on a 0 and the right pair on a 1, and forwards the chosen child pointer, the address and the best next hop found so far. A match found deeper in the trie replaces a shallower one, so the result is the next hop of the longest stored prefix that matches.

Addresses enter on a valid/ready stream at one per cycle. Results leave in input order on a second valid/ready stream, as a next-hop code and a hit flag. A node write port loads the trie. It writes one whole node, at a chosen node index, into the RAM of a chosen stage. Next-hop code 0 means "no prefix stored here". Child pointer 0 means "no child". The root is node 0 of stage 0. A prefix of length l lives in the stage l−1 node reached by its first l−1 bits, on the side given by its last bit.

Top module: `trie_lpm_pipe`

## Requirements
- R1: Stage k (root stage 0) tests address bit ADDR_W-1-k. A 0 selects the left (child, hop) pair of the node and a 1 selects the right pair.
- R2: A non-zero hop seen at a deeper stage replaces the carried best match. When out_hit is high, out_hop is the hop of the longest matching stored prefix and is non-zero.
- R3: A hop field of 0 on the selected side leaves the carried best match unchanged.
- R4: A selected child pointer of 0 ends the walk. No later stage changes the result, whatever its RAM holds.
- R5: When no stored prefix matches, out_hit is 0 and out_hop is 0.
- R6: With out_ready high, a new address is accepted every cycle. Each result appears STAGES+1 rising edges after the edge before which the address was driven, that is, STAGES edges after the accepting edge. Results leave in acceptance order, and no more than STAGES+1 lookups are ever in flight.
- R7: While out_valid is high and out_ready is low, out_valid, out_hop and out_hit hold steady and in_ready is low.
- R8: A cycle with wr_en high writes {wr_lchild, wr_lhop, wr_rchild, wr_rhop} to node wr_node of stage wr_stage. Later lookups use the new contents.
- R9: After reset, out_valid is low and in_ready is high.
- R10: Prefixes up to STAGES bits long are resolved, the longest by the last stage. Address bits below the top STAGES bits do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Address present |
| in_ready | output | 1 | Address accepted this cycle when valid |
| in_addr | input | ADDR_W | Destination address |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_hop | output | HOP_W | Next hop of the longest match, 0 on miss |
| out_hit | output | 1 | A prefix matched |
| wr_en | input | 1 | Node write strobe |
| wr_stage | input | $clog2(STAGES) | Stage whose RAM is written |
| wr_node | input | PTR_W | Node index written |
| wr_lchild | input | PTR_W | Left child pointer (0 = none) |
| wr_lhop | input | HOP_W | Left next hop (0 = none) |
| wr_rchild | input | PTR_W | Right child pointer (0 = none) |
| wr_rhop | input | HOP_W | Right next hop (0 = none) |

## Verification
The bench builds the engine with its defaults: 32-bit addresses, 8 stages, 8-bit next hops and 64 nodes per stage. With these values, prefixes of every length from 1 to 8 bits sit on one path, and nested matches, null hops and early null children can all be placed at every depth. The full pipeline depth of 9 cycles stays short enough for streams of dozens of lookups under steady and stalled output, where ordering and holding are checked against a longest-prefix model.

// File: rtl/trie_lpm_pipe.sv
module trie_lpm_pipe #(
  parameter int ADDR_W = 32,
  parameter int STAGES = 8,
  parameter int HOP_W  = 8,
  parameter int PTR_W  = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [ADDR_W-1:0]         in_addr,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [HOP_W-1:0]          out_hop,
  output logic                      out_hit,
  input  logic                      wr_en,
  input  logic [$clog2(STAGES)-1:0] wr_stage,
  input  logic [PTR_W-1:0]          wr_node,
  input  logic [PTR_W-1:0]          wr_lchild,
  input  logic [HOP_W-1:0]          wr_lhop,
  input  logic [PTR_W-1:0]          wr_rchild,
  input  logic [HOP_W-1:0]          wr_rhop
);
  localparam int NODES  = 1 << PTR_W;
  localparam int NODE_W = 2 * (PTR_W + HOP_W);
  localparam int SEL_W  = $clog2(STAGES);

  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  logic [STAGES-1:0]                 v_w;
  logic [STAGES-1:0]                 alive_w;
  logic [STAGES-1:0][PTR_W-1:0]      child_w;
  logic [STAGES-1:0][HOP_W-1:0]      best_w;
  logic [STAGES-1:0][STAGES-1:0]     key_w;

  logic addr_unused;
  assign addr_unused = ^in_addr[ADDR_W-STAGES-1:0];

  for (genvar k = 0; k < STAGES; k++) begin : stg
    logic [NODE_W-1:0] mem [NODES];
    logic [NODE_W-1:0] q;
    logic              v, alive;
    logic [STAGES-1:0] key;
    logic [HOP_W-1:0]  best;
    logic [PTR_W-1:0]  rd_ptr;
    logic              rd_en;
    logic [PTR_W-1:0]  lc, rc, child;
    logic [HOP_W-1:0]  lh, rh, hop;
    logic              sel;

    always_ff @(posedge clk)
      if (wr_en && wr_stage == SEL_W'(k))
        mem[wr_node] <= {wr_lchild, wr_lhop, wr_rchild, wr_rhop};

    always_ff @(posedge clk)
      if (rd_en) q <= mem[rd_ptr];

    if (k == 0) begin : g_head
      assign rd_ptr = '0;
      assign rd_en  = adv && in_valid;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          v <= 1'b0; alive <= 1'b0; key <= '0; best <= '0;
        end else if (adv) begin
          v     <= in_valid;
          alive <= 1'b1;
          key   <= in_addr[ADDR_W-1 -: STAGES];
          best  <= '0;
        end
    end else begin : g_body
      assign rd_ptr = child_w[k-1];
      assign rd_en  = adv && v_w[k-1] && alive_w[k-1];
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          v <= 1'b0; alive <= 1'b0; key <= '0; best <= '0;
        end else if (adv) begin
          v     <= v_w[k-1];
          alive <= alive_w[k-1];
          key   <= key_w[k-1];
          best  <= best_w[k-1];
        end
    end

    assign {lc, lh, rc, rh} = q;
    assign sel   = key[STAGES-1-k];
    assign hop   = sel ? rh : lh;
    assign child = sel ? rc : lc;

    assign v_w[k]     = v;
    assign key_w[k]   = key;
    assign child_w[k] = child;
    assign alive_w[k] = alive && (child != '0);
    assign best_w[k]  = (alive && hop != '0) ? hop : best;
  end

  logic tail_unused;
  assign tail_unused = ^{child_w[STAGES-1], alive_w[STAGES-1], key_w[STAGES-1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hop   <= '0;
      out_hit   <= 1'b0;
    end else if (adv) begin
      out_valid <= v_w[STAGES-1];
      out_hop   <= best_w[STAGES-1];
      out_hit   <= |best_w[STAGES-1];
    end
endmodule

module trie_lpm_pipe_chk #(
  parameter int STAGES = 8,
  parameter int HOP_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [HOP_W-1:0] out_hop,
  input logic             out_hit
);
  localparam int CW = $clog2(STAGES + 2) + 1;
  logic [CW-1:0] inflight;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + CW'(in_valid && in_ready) - CW'(out_valid && out_ready);

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid && in_ready); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_hop) && $stable(out_hit)); // R7
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_hit |-> out_hop == '0); // R5
  AST_HIT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hit |-> out_hop != '0); // R2
  AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CW'(STAGES + 1)); // R6
endmodule

bind trie_lpm_pipe trie_lpm_pipe_chk #(.STAGES(STAGES), .HOP_W(HOP_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_hop(out_hop), .out_hit(out_hit)
);

// File: tb/trie_lpm_pipe_tb.sv
module trie_lpm_pipe_tb_top;
  localparam int ADDR_W = 32, STAGES = 8, HOP_W = 8, PTR_W = 6;
  localparam int NODES = 1 << PTR_W;
  localparam int SW = $clog2(STAGES);

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 1, wr_en = 0;
  logic in_ready, out_valid, out_hit;
  logic [ADDR_W-1:0] in_addr = '0;
  logic [HOP_W-1:0]  out_hop, wr_lhop = '0, wr_rhop = '0;
  logic [SW-1:0]     wr_stage = '0;
  logic [PTR_W-1:0]  wr_node = '0, wr_lchild = '0, wr_rchild = '0;

  always #5 clk = ~clk;

  trie_lpm_pipe #(.ADDR_W(ADDR_W), .STAGES(STAGES), .HOP_W(HOP_W), .PTR_W(PTR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_hop(out_hop), .out_hit(out_hit),
    .wr_en(wr_en), .wr_stage(wr_stage), .wr_node(wr_node), .wr_lchild(wr_lchild),
    .wr_lhop(wr_lhop), .wr_rchild(wr_rchild), .wr_rhop(wr_rhop));

  int n_tests = 0, n_fail = 0;

  logic [PTR_W-1:0] sh_lc [STAGES][NODES];
  logic [PTR_W-1:0] sh_rc [STAGES][NODES];
  logic [HOP_W-1:0] sh_lh [STAGES][NODES];
  logic [HOP_W-1:0] sh_rh [STAGES][NODES];
  int nxt [STAGES];

  int np = 0;
  logic [7:0] pf_bits [16];
  int         pf_len  [16];
  int         pf_hop  [16];

  localparam logic [7:0] TOPS [12] = '{8'h00, 8'h40, 8'h80, 8'hF0, 8'hC0, 8'hF8,
                                       8'hE0, 8'hD4, 8'hD6, 8'hAA, 8'hAB, 8'hA8};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model(input logic [ADDR_W-1:0] a);
    int best = 0, bl = 0;
    for (int i = 0; i < np; i++)
      if (pf_len[i] > bl && (a[31:24] >> (8 - pf_len[i])) == (pf_bits[i] >> (8 - pf_len[i]))) begin
        best = pf_hop[i];
        bl   = pf_len[i];
      end
    return best;
  endfunction

  task automatic add_prefix(input logic [7:0] bits, input int len, input int hop);
    int node = 0;
    for (int lv = 0; lv < len - 1; lv++) begin
      int ch = bits[7-lv] ? int'(sh_rc[lv][node]) : int'(sh_lc[lv][node]);
      if (ch == 0) begin
        ch = nxt[lv+1];
        nxt[lv+1]++;
        if (bits[7-lv]) sh_rc[lv][node] = PTR_W'(ch);
        else            sh_lc[lv][node] = PTR_W'(ch);
      end
      node = ch;
    end
    if (bits[8-len]) sh_rh[len-1][node] = HOP_W'(hop);
    else             sh_lh[len-1][node] = HOP_W'(hop);
    pf_bits[np] = bits; pf_len[np] = len; pf_hop[np] = hop; np++;
  endtask

  task automatic write_node(input int s, input int n);
    @(negedge clk);
    wr_en = 1; wr_stage = SW'(s); wr_node = PTR_W'(n);
    wr_lchild = sh_lc[s][n]; wr_lhop = sh_lh[s][n];
    wr_rchild = sh_rc[s][n]; wr_rhop = sh_rh[s][n];
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic load_trie;
    for (int s = 0; s < STAGES; s++) begin
      nxt[s] = 1;
      for (int n = 0; n < NODES; n++) begin
        sh_lc[s][n] = '0; sh_rc[s][n] = '0; sh_lh[s][n] = '0; sh_rh[s][n] = '0;
      end
    end
    add_prefix(8'b0000_0000, 1, 11);
    add_prefix(8'b1100_0000, 2, 22);
    add_prefix(8'b1100_0000, 3, 33);
    add_prefix(8'b1110_0000, 4, 44);
    add_prefix(8'b1100_0000, 5, 55);
    add_prefix(8'b1111_1000, 5, 66);
    add_prefix(8'b1101_0100, 7, 77);
    add_prefix(8'b1010_1010, 8, 88);
    for (int s = 0; s < STAGES; s++)
      for (int n = 0; n < NODES; n++) write_node(s, n);
  endtask

  task automatic t_reset;
    #1;
    chk(out_valid == 0, "R9 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1, "R9 in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic lookup_one(input logic [ADDR_W-1:0] a, input string req);
    int cyc = 0;
    int exp = model(a);
    @(negedge clk);
    out_ready = 1; in_valid = 1; in_addr = a;
    @(negedge clk);
    in_valid = 0; cyc = 1;
    while (!out_valid && cyc < 50) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == STAGES + 1, "R6 latency", cyc, STAGES + 1);
    chk(out_hop == HOP_W'(exp), req, int'(out_hop), exp);
    chk(out_hit == (exp != 0), {req, " hit"}, int'(out_hit), int'(exp != 0));
  endtask

  task automatic t_directed;
    lookup_one(32'h0000_0000, "R1 left at root");
    lookup_one(32'h4000_0000, "R1 left, deeper bits ignored");
    lookup_one(32'h8000_0000, "R5 miss");
    lookup_one(32'hF000_0000, "R3 null hops keep match");
    lookup_one(32'hC000_0000, "R2 deeper override");
    lookup_one(32'hF800_0000, "R2 right-side override");
    lookup_one(32'hE000_0000, "R1 mixed path");
    lookup_one(32'hD400_0000, "R2 length 7");
    lookup_one(32'hD600_0000, "R4 null child ends walk");
    lookup_one(32'hAA00_0000, "R10 length 8");
    lookup_one(32'hAB12_3456, "R5 last-bit mismatch miss");
    lookup_one(32'hAAFF_FFFF, "R10 low bits ignored");
    lookup_one(32'hA800_0000, "R5 miss off long path");
  endtask

  function automatic logic [ADDR_W-1:0] pick(input int i);
    logic [7:0] top = (i < 12) ? TOPS[i] : 8'(i * 53 + 7);
    return {top, 24'(i * 40503)};
  endfunction

  task automatic t_stream(input bit stall, input string req);
    logic [HOP_W-1:0] expq [$];
    logic [HOP_W-1:0] hh = '0;
    bit held = 0;
    int sent = 0;
    localparam int N = 48;
    for (int c = 0; c < 800 && (sent < N || expq.size() > 0); c++) begin
      @(negedge clk);
      out_ready = stall ? (c % 3 != 0) : 1'b1;
      in_valid = (sent < N);
      in_addr  = pick(sent);
      #1;
      if (held) chk(out_valid && out_hop == hh, {req, " R7 hold"}, int'(out_hop), int'(hh));
      if (out_valid && !out_ready) begin
        held = 1; hh = out_hop;
        chk(!in_ready, {req, " R7 input blocked"}, int'(in_ready), 0);
      end else held = 0;
      if (out_valid && out_ready) begin
        if (expq.size() == 0) chk(0, {req, " R6 extra result"}, int'(out_hop), -1);
        else begin
          logic [HOP_W-1:0] e = expq.pop_front();
          chk(out_hop == e, {req, " R6 in-order result"}, int'(out_hop), int'(e));
        end
      end
      if (in_valid && in_ready) begin
        expq.push_back(HOP_W'(model(in_addr)));
        sent++;
      end
    end
    in_valid = 0; out_ready = 1;
    chk(sent == N && expq.size() == 0, {req, " R6 all delivered"}, sent, N);
  endtask

  task automatic t_rewrite;
    int n1 = int'(sh_rc[0][0]);
    sh_rh[1][n1] = 8'd99;
    pf_hop[1] = 99;
    write_node(1, n1);
    lookup_one(32'hF000_0000, "R8 rewritten hop");
    lookup_one(32'hC000_0000, "R8 other entries intact");
  endtask

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    load_trie();
    t_directed();
    t_stream(0, "steady");
    t_stream(1, "stalled");
    t_rewrite();
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule